// File: doc/BRIEF.md
# Fractional Multiply-Subtract Unit

This block is a one-stage execution datapath for signed fixed-point multiply-subtract. One 32-bit instruction word selects the operation. Two 32-bit multiplicand values and a 64-bit minuend value are supplied on ports. The block multiplies the two multiplicands. It can shift the product left by one place so that Q-format fractions stay aligned. It then subtracts the product from the minuend.

Each operation returns either a 32-bit fraction or a 64-bit multi-precision result. The 32-bit fraction keeps only the upper part of the aligned product. The second multiplicand is either the full 32-bit value or its sign-extended lower halfword. All arithmetic is carried out exactly before anything is truncated. An overflow flag reports when the exact result does not fit the destination. A saturation input chooses between two behaviours on overflow: the result either wraps or is clamped to the nearest representable limit.

The issue stage presents an operation with `in_valid`. The result, with its flags, is registered and appears on the following cycle.

Top module: `qmsub_unit`

## Requirements
- R1: The instruction is decoded from three fields. Bits 7:0 hold the primary opcode, which must equal 0x63. Bits 23:18 hold the variant code: 0x02 is 32x32 with a 32-bit result, 0x1B is 32x32 with a 64-bit result, 0x01 is 32x16 with a 32-bit result, and 0x19 is 32x16 with a 64-bit result. Bits 17:16 hold the shift n. The register index fields (bits 31:24 and 15:8) do not affect the result.
- R2: For variant 0x02, result[31:0] is the low 32 bits of minuend[31:0] − floor((a·b << n) / 2^32).
- R3: For variant 0x1B, result[63:0] is minuend − (a·b << n), modulo 2^64.
- R4: For variant 0x01, b is the sign-extended value op_b[15:0], and result[31:0] is minuend[31:0] − floor((a·b << n) / 2^16).
- R5: For variant 0x19, result[63:0] is minuend − (a·sext(op_b[15:0]) << n), modulo 2^64.
- R6: In the 32-bit result forms, result[63:32] is zero and minuend[63:32] has no effect.
- R7: `ovf` is 1 exactly when the exact signed result lies outside the signed range of the destination width (32 or 64 bits). This holds whether or not saturation is on.
- R8: With `sat_en` = 1 and an overflow, the destination part of the result is clamped to 0x7FFFFFFF or 0x80000000 (32-bit form), or to 0x7FFFFFFFFFFFFFFF or 0x8000000000000000 (64-bit form), according to the sign of the exact result. When there is no overflow, `sat_en` has no effect.
- R9: The operation is illegal if n is 2 or 3, if the primary opcode is not 0x63, or if the variant code is none of the four codes. An illegal operation gives `illegal` = 1, `result` = 0 and `ovf` = 0.
- R10: Each operation accepted with `in_valid` = 1 appears on the outputs one clock later, with `out_valid` = 1. A cycle with `in_valid` = 0 clears `out_valid` and leaves `result` unchanged.
- R11: While reset is asserted, `out_valid`, `result`, `ovf` and `illegal` are all zero.
- R12: The product is kept at full precision. 0x80000000·0x80000000 with n = 1 in variant 0x1B and a zero minuend gives 0x8000000000000000 with no overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| instr | input | 32 | Instruction word |
| op_a | input | 32 | First multiplicand |
| op_b | input | 32 | Second multiplicand (halfword forms use bits 15:0) |
| minuend | input | 64 | Value the product is subtracted from (32-bit forms use bits 31:0) |
| sat_en | input | 1 | 1 clamps on overflow, 0 wraps |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Registered result |
| ovf | output | 1 | Exact result did not fit the destination |
| illegal | output | 1 | Operation was undefined; result forced to zero |

## Verification
Overflow detection and saturation act on the same result in the same cycle. Operands that push the exact result past the 32-bit or the 64-bit limit are applied twice, once with `sat_en` low and once with it high. The bench then checks that the flag is raised in both runs, and that the result wraps in the first and is clamped in the second. An undefined shift amount is also applied together with operands that would overflow. In that case the illegal-operation flag must win: the overflow flag stays clear and the result is zero.

// File: rtl/qmsub_pkg.sv
package qmsub_pkg;
  localparam int unsigned PRI_LSB = 0;
  localparam int unsigned PRI_W   = 8;
  localparam int unsigned SH_LSB  = 16;
  localparam int unsigned SH_W    = 2;
  localparam int unsigned VAR_LSB = 18;
  localparam int unsigned VAR_W   = 6;

  localparam logic [PRI_W-1:0] PRI_QMSUB = 8'h63;
  localparam logic [VAR_W-1:0] VAR_N_FULL = 6'h02;
  localparam logic [VAR_W-1:0] VAR_W_FULL = 6'h1B;
  localparam logic [VAR_W-1:0] VAR_N_HALF = 6'h01;
  localparam logic [VAR_W-1:0] VAR_W_HALF = 6'h19;

  typedef struct packed {
    logic wide;
    logic half;
    logic shl;
    logic bad;
  } qmsub_ctl_t;
endpackage

// File: rtl/qmsub_decode.sv
module qmsub_decode
  import qmsub_pkg::*;
#(
  parameter int unsigned IW = 32
) (
  input  logic [IW-1:0] instr,
  output qmsub_ctl_t    ctl
);
  logic [PRI_W-1:0] pri;
  logic [VAR_W-1:0] vsel;
  logic [SH_W-1:0]  sh;

  assign pri  = instr[PRI_LSB +: PRI_W];
  assign vsel = instr[VAR_LSB +: VAR_W];
  assign sh   = instr[SH_LSB +: SH_W];

  always_comb begin
    ctl = '0;
    unique case (vsel)
      VAR_N_FULL: begin ctl.wide = 1'b0; ctl.half = 1'b0; end
      VAR_W_FULL: begin ctl.wide = 1'b1; ctl.half = 1'b0; end
      VAR_N_HALF: begin ctl.wide = 1'b0; ctl.half = 1'b1; end
      VAR_W_HALF: begin ctl.wide = 1'b1; ctl.half = 1'b1; end
      default:    ctl.bad = 1'b1;
    endcase
    ctl.shl = sh[0];
    if (pri != PRI_QMSUB || sh[SH_W-1:1] != '0) ctl.bad = 1'b1;
  end
endmodule

// File: rtl/qmsub_align.sv
module qmsub_align
  import qmsub_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned HALF = 16,
  localparam int unsigned ACC  = 2 * XLEN,
  localparam int unsigned EXTW = ACC + 3
) (
  input  logic [XLEN-1:0]        op_a,
  input  logic [XLEN-1:0]        op_b,
  input  qmsub_ctl_t             ctl,
  output logic signed [EXTW-1:0] term
);
  logic signed [XLEN-1:0] b_sel;
  logic signed [ACC-1:0]  prod;
  logic signed [EXTW-1:0] prod_x;
  logic signed [EXTW-1:0] aligned;

  assign b_sel  = ctl.half ? {{(XLEN-HALF){op_b[HALF-1]}}, op_b[HALF-1:0]} : op_b;
  assign prod   = $signed(op_a) * b_sel;
  assign prod_x = {{(EXTW-ACC){prod[ACC-1]}}, prod};
  assign aligned = ctl.shl ? (prod_x <<< 1) : prod_x;

  always_comb begin
    if (ctl.wide)      term = aligned;
    else if (ctl.half) term = aligned >>> HALF;
    else               term = aligned >>> XLEN;
  end
endmodule

// File: rtl/qmsub_subsat.sv
module qmsub_subsat #(
  parameter int unsigned XLEN = 32,
  localparam int unsigned ACC  = 2 * XLEN,
  localparam int unsigned EXTW = ACC + 3
) (
  input  logic [ACC-1:0]         minuend,
  input  logic signed [EXTW-1:0] term,
  input  logic                   wide,
  input  logic                   sat_en,
  output logic [ACC-1:0]         res,
  output logic                   ovf
);
  localparam logic [XLEN-1:0] N_MAX = {1'b0, {(XLEN-1){1'b1}}};
  localparam logic [XLEN-1:0] N_MIN = {1'b1, {(XLEN-1){1'b0}}};
  localparam logic [ACC-1:0]  W_MAX = {1'b0, {(ACC-1){1'b1}}};
  localparam logic [ACC-1:0]  W_MIN = {1'b1, {(ACC-1){1'b0}}};

  logic signed [EXTW-1:0] min_x;
  logic signed [EXTW-1:0] exact;
  logic [EXTW-XLEN:0]     n_top;
  logic [EXTW-ACC:0]      w_top;
  logic                   neg;

  assign min_x = wide ? {{(EXTW-ACC){minuend[ACC-1]}}, minuend}
                      : {{(EXTW-XLEN){minuend[XLEN-1]}}, minuend[XLEN-1:0]};
  assign exact = min_x - term;
  assign neg   = exact[EXTW-1];
  assign n_top = exact[EXTW-1:XLEN-1];
  assign w_top = exact[EXTW-1:ACC-1];

  always_comb begin
    if (wide) ovf = !((w_top == '0) || (w_top == '1));
    else      ovf = !((n_top == '0) || (n_top == '1));
    if (ovf && sat_en) begin
      if (wide) res = neg ? W_MIN : W_MAX;
      else      res = {{XLEN{1'b0}}, (neg ? N_MIN : N_MAX)};
    end else begin
      res = wide ? exact[ACC-1:0] : {{XLEN{1'b0}}, exact[XLEN-1:0]};
    end
  end
endmodule

// File: rtl/qmsub_unit.sv
module qmsub_unit
  import qmsub_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned HALF = 16,
  localparam int unsigned ACC  = 2 * XLEN,
  localparam int unsigned EXTW = ACC + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic [ACC-1:0]  minuend,
  input  logic            sat_en,
  output logic            out_valid,
  output logic [ACC-1:0]  result,
  output logic            ovf,
  output logic            illegal
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  qmsub_ctl_t             ctl;
  logic signed [EXTW-1:0] term;
  logic [ACC-1:0]         ss_res;
  logic                   ss_ovf;

  qmsub_decode #(.IW(32)) u_dec (.instr(instr), .ctl(ctl));

  qmsub_align #(.XLEN(XLEN), .HALF(HALF)) u_aln (
    .op_a(op_a), .op_b(op_b), .ctl(ctl), .term(term)
  );

  qmsub_subsat #(.XLEN(XLEN)) u_sub (
    .minuend(minuend), .term(term), .wide(ctl.wide), .sat_en(sat_en),
    .res(ss_res), .ovf(ss_ovf)
  );

  logic [ACC-1:0] res_d;
  logic           ovf_d, ill_d;
  logic           wide_q, sat_q;

  always_comb begin
    res_d = ctl.bad ? '0 : ss_res;
    ovf_d = ss_ovf && !ctl.bad;
    ill_d = ctl.bad;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf       <= 1'b0;
      illegal   <= 1'b0;
      wide_q    <= 1'b0;
      sat_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= res_d;
        ovf     <= ovf_d;
        illegal <= ill_d;
        wide_q  <= ctl.wide;
        sat_q   <= sat_en;
      end
    end
  end

  // R9: undefined shift amount must be reported and zero the result
  a_r9_undefined_shift: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid && instr[SH_LSB+1] |=> illegal && result == '0);

  // R9: an illegal operation never reports overflow
  a_r9_illegal_no_ovf: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && illegal |-> !ovf);

  // R6: narrow forms leave the upper half zero
  a_r6_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && !wide_q && !illegal |-> result[ACC-1:XLEN] == '0);

  // R8: a clamped narrow result sits on a limit
  a_r8_clamp_narrow: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid && ovf && sat_q && !wide_q |->
      (result[XLEN-1:0] == {1'b0, {(XLEN-1){1'b1}}}) ||
      (result[XLEN-1:0] == {1'b1, {(XLEN-1){1'b0}}}));

  // R10: idle cycles hold the result and clear the valid
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> $stable(result) && !out_valid);
endmodule

// File: tb/tb_qmsub_unit.sv
module tb_qmsub_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  logic        clk, rst_n, in_valid, sat_en;
  logic [31:0] instr, op_a, op_b;
  logic [63:0] minuend;
  logic        out_valid, ovf, illegal;
  logic [63:0] result;

  qmsub_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .op_a(op_a), .op_b(op_b), .minuend(minuend), .sat_en(sat_en),
    .out_valid(out_valid), .result(result), .ovf(ovf), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Vectors: R2 R6 R2 R3 R3 R4 R4 R5 R7 R8 R8 R12 R7 R8 R8 R9 R9 R9 R9 R8
  localparam int T_REQ [NV] = '{2, 6, 2, 3, 3, 4, 4, 5, 7, 8, 8, 12, 7, 8, 8, 9, 9, 9, 9, 8};
  localparam logic [5:0] T_SEC [NV] = '{6'h02, 6'h02, 6'h02, 6'h1B, 6'h1B, 6'h01, 6'h01, 6'h19,
    6'h02, 6'h02, 6'h02, 6'h1B, 6'h1B, 6'h1B, 6'h02, 6'h02, 6'h1B, 6'h02, 6'h03, 6'h19};
  localparam logic [1:0] T_N [NV] = '{2'd1, 2'd0, 2'd0, 2'd1, 2'd0, 2'd1, 2'd0, 2'd1,
    2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0, 2'd0};
  localparam logic [7:0] T_PRI [NV] = '{8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h63,
    8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h63, 8'h62, 8'h63, 8'h63};
  localparam logic [31:0] T_A [NV] = '{32'h40000000, 32'h40000000, 32'hFFFFFFFF, 32'h3,
    32'hFFFFFFFE, 32'h40000000, 32'h00010000, 32'h10, 32'h80000000, 32'h80000000,
    32'h40000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h40000000, 32'h80000000,
    32'h80000000, 32'h3, 32'h3, 32'hFFFFFFFF};
  localparam logic [31:0] T_B [NV] = '{32'h40000000, 32'h40000000, 32'h1, 32'h5,
    32'h7, 32'hABCD4000, 32'h00008000, 32'hFFFF0003, 32'h7FFFFFFF, 32'h7FFFFFFF,
    32'h40000000, 32'h80000000, 32'h80000000, 32'h80000000, 32'h40000000, 32'h7FFFFFFF,
    32'h80000000, 32'h5, 32'h5, 32'h00000001};
  localparam logic [63:0] T_M [NV] = '{64'h40000000, 64'hFFFFFFFF40000000, 64'h0, 64'h64,
    64'h0, 64'h0, 64'h100, 64'h100000000, 64'h7FFFFFFF, 64'h7FFFFFFF,
    64'h80000000, 64'h0, 64'hFFFFFFFFFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 64'h40000000, 64'h7FFFFFFF,
    64'hFFFFFFFFFFFFFFFF, 64'h64, 64'h64, 64'h7FFFFFFFFFFFFFFF};
  localparam logic T_SAT [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
  localparam logic [63:0] T_EXP [NV] = '{64'h20000000, 64'h30000000, 64'h1, 64'h46,
    64'hE, 64'hE0000000, 64'h8100, 64'hFFFFFFA0, 64'hFFFFFFFE, 64'h7FFFFFFF,
    64'h80000000, 64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF, 64'h8000000000000000, 64'h20000000, 64'h0,
    64'h0, 64'h0, 64'h0, 64'h7FFFFFFFFFFFFFFF};
  localparam logic T_OVF [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
  localparam logic T_ILL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  task automatic chk(input string req, input string what, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; sat_en = 1'b0;
    instr = '0; op_a = '0; op_b = '0; minuend = '0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "out_valid in reset", {63'b0, out_valid}, 64'h0);
    chk("R11", "result in reset", result, 64'h0);
    chk("R11", "flags in reset", {62'b0, ovf, illegal}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d", T_REQ[i]);
      // R1: register index fields carry arbitrary nonzero values
      instr    = {4'(i + 1), 4'(i + 5), T_SEC[i], T_N[i], 4'(i + 9), 4'(i + 3), T_PRI[i]};
      op_a     = T_A[i];
      op_b     = T_B[i];
      minuend  = T_M[i];
      sat_en   = T_SAT[i];
      in_valid = 1'b1;
      @(negedge clk);
      chk(rq, $sformatf("vec%0d result", i), result, T_EXP[i]);
      chk(rq, $sformatf("vec%0d ovf", i), {63'b0, ovf}, {63'b0, T_OVF[i]});
      chk(rq, $sformatf("vec%0d illegal", i), {63'b0, illegal}, {63'b0, T_ILL[i]});
      chk("R10", $sformatf("vec%0d out_valid", i), {63'b0, out_valid}, 64'h1);
    end

    // R10: idle cycle with changed operands holds the last result
    in_valid = 1'b0;
    instr = {4'h0, 4'h0, 6'h1B, 2'd0, 4'h0, 4'h0, 8'h63};
    op_a = 32'h12345678; op_b = 32'h9ABCDEF0; minuend = 64'h1;
    @(negedge clk);
    chk("R10", "idle out_valid", {63'b0, out_valid}, 64'h0);
    chk("R10", "idle result held", result, 64'h7FFFFFFFFFFFFFFF);
    @(negedge clk);
    chk("R10", "idle result held 2", result, 64'h7FFFFFFFFFFFFFFF);

    // R6: narrow form sees only minuend[31:0]
    instr = {4'h0, 4'h0, 6'h01, 2'd0, 4'h0, 4'h0, 8'h63};
    op_a = 32'h0; op_b = 32'h0; minuend = 64'hDEADBEEF00000005; sat_en = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    chk("R6", "narrow upper ignored", result, 64'h5);

    // R11: asynchronous reset mid-run clears outputs
    in_valid = 1'b0;
    #2 rst_n = 1'b0;
    #1;
    chk("R11", "async reset result", result, 64'h0);
    chk("R11", "async reset valid", {63'b0, out_valid}, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule